// File: doc/BRIEF.md
# Magnitude-Mode Polarity and No-Load Gate

This block sits between the filtered, signed power word of an energy meter and the pulse generator that drives the low-frequency stepper outputs. In the magnitude-only operating modes it forwards the absolute value of each power word. If that magnitude falls under a programmable creep floor, it forwards zero, so accumulation stops and the stepper outputs go quiet. This is how a mechanical meter held by friction behaves at no load. In the sign-and-magnitude modes the signed word passes through untouched and no floor applies.

The block also keeps a sticky reverse-power indicator. Each accepted word records whether it carried negative power. The indicator sets only when the pulse generator reports that a stepper pulse was actually emitted while that record is still negative. Once set, the indicator stays high until reset.

Top module: `mag_polarity_gate`

## Requirements
- R1: After reset, `out_valid` is 0, `out_word` is 0 and `rev_flag` is 0.
- R2: One clock after a cycle with `pwr_valid` high, `out_valid` is high for exactly one cycle with that word's result. `out_valid` is never high otherwise.
- R3: A mode whose two low bits differ (1, 2, 5, 6) is magnitude-only. Any other mode (0, 3, 4, 7) forwards the signed input word unchanged.
- R4: In magnitude-only modes the result is the absolute value of the input. The most negative code maps to the largest positive code, 2^(W-1)-1.
- R5: In magnitude-only modes, a magnitude strictly below the threshold yields 0. A magnitude equal to the threshold is forwarded.
- R6: A threshold input of 0 selects the default floor floor(2^(W-1)*48/10^7), which is 40 for W=24.
- R7: In sign-and-magnitude modes the threshold has no effect, and a word below it is still forwarded.
- R8: `rev_flag` rises one clock after a `pulse_evt` strobe when the most recent accepted word was negative, in a magnitude-only mode, and not blocked by the floor.
- R9: A `pulse_evt` leaves `rev_flag` low when the most recent word was positive, was blocked by the floor, or arrived in a sign-and-magnitude mode. A negative word with no pulse also leaves it low.
- R10: Once set, `rev_flag` stays high through any later words, modes and pulses until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_valid | input | 1 | Power word strobe |
| pwr_word | input | W | Signed filtered power word |
| mode | input | 3 | Operating mode |
| nl_thresh | input | W | No-load floor, 0 selects the default |
| pulse_evt | input | 1 | Stepper pulse emitted, from the pulse generator |
| out_valid | output | 1 | Result strobe |
| out_word | output | W | Gated magnitude or passed-through signed word |
| rev_flag | output | 1 | Sticky reverse-power indicator |

## Verification
The bench aims at the comparison boundary: one code below the floor and exactly at the floor. A design using less-or-equal would zero the equal case, and one using the wrong bound would pass the lower one. The most negative input is checked, because a plain two's-complement negate returns it unchanged as a negative word. The reverse indicator is probed with several strobe patterns. A design that latches on sign alone would rise without a pulse. A design that ignores the floor or the mode would rise on a blocked or sign-and-magnitude word. A design that is not sticky would drop after a later positive word.

// File: rtl/mag_polarity_gate.sv
module mag_polarity_gate #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_valid,
  input  logic [W-1:0] pwr_word,
  input  logic [2:0]   mode,
  input  logic [W-1:0] nl_thresh,
  input  logic         pulse_evt,
  output logic         out_valid,
  output logic [W-1:0] out_word,
  output logic         rev_flag
);

  localparam logic [63:0]  FLOOR64 = ((64'd1 << (W-1)) * 64'd48) / 64'd10000000;
  localparam logic [W-1:0] DEF_THR = FLOOR64[W-1:0];
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic         mag_mode;
  logic         is_neg;
  logic [W-1:0] magnitude;
  logic [W-1:0] floor_val;
  logic         blocked;
  logic [W-1:0] result;
  logic         neg_pend;

  assign mag_mode  = mode[1] ^ mode[0];
  assign is_neg    = pwr_word[W-1];
  assign magnitude = (pwr_word == MIN_NEG) ? MAX_POS :
                     is_neg ? (~pwr_word + 1'b1) : pwr_word;
  assign floor_val = (nl_thresh == '0) ? DEF_THR : nl_thresh;
  assign blocked   = magnitude < floor_val;
  assign result    = !mag_mode ? pwr_word : (blocked ? '0 : magnitude);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      neg_pend  <= 1'b0;
      rev_flag  <= 1'b0;
    end else begin
      out_valid <= pwr_valid;
      if (pwr_valid) begin
        out_word <= result;
        neg_pend <= mag_mode & is_neg & ~blocked;
      end
      if (pulse_evt && neg_pend)
        rev_flag <= 1'b1;
    end
  end

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_valid |=> out_valid);

  p_valid_only_after_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_valid |=> !out_valid);

  p_mag_non_negative_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_valid && mag_mode) |=> !out_word[W-1]);

  p_rev_needs_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rev_flag && !pulse_evt) |=> !rev_flag);

  p_rev_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rev_flag |=> rev_flag);

endmodule

// File: tb/tb_mag_polarity_gate.sv
module tb_mag_polarity_gate;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwr_valid = 1'b0;
  logic [W-1:0] pwr_word = '0;
  logic [2:0]   mode = 3'd0;
  logic [W-1:0] nl_thresh = '0;
  logic         pulse_evt = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_word;
  logic         rev_flag;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  mag_polarity_gate #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_valid(pwr_valid), .pwr_word(pwr_word),
    .mode(mode), .nl_thresh(nl_thresh), .pulse_evt(pulse_evt),
    .out_valid(out_valid), .out_word(out_word), .rev_flag(rev_flag));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expect_of(input logic [2:0] m, input logic [W-1:0] w,
                                             input logic [W-1:0] t);
    longint v, a, th;
    v  = longint'($signed(w));
    a  = (v < 0) ? -v : v;
    if (a > 64'sd8388607) a = 64'sd8388607;
    th = (t == 0) ? 40 : longint'(t);
    if (m == 3'd0 || m == 3'd3 || m == 3'd4 || m == 3'd7) return w;
    if (a < th) return '0;
    return a[W-1:0];
  endfunction

  task automatic send(input string req, input logic [2:0] m, input logic [W-1:0] w,
                      input logic [W-1:0] t);
    @(negedge clk);
    mode = m; pwr_word = w; nl_thresh = t; pwr_valid = 1'b1;
    exp_q.push_back(expect_of(m, w, t));
    tag_q.push_back(req);
    @(negedge clk);
    pwr_valid = 1'b0;
  endtask

  task automatic pulse_and_check(input string req, input logic exp_rev);
    @(negedge clk);
    pulse_evt = 1'b1;
    @(negedge clk);
    pulse_evt = 1'b0;
    check(req, {{(W-1){1'b0}}, rev_flag}, {{(W-1){1'b0}}, exp_rev});
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: actual unexpected out_valid expected none");
      end else begin
        check(tag_q.pop_front(), out_word, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", {{(W-1){1'b0}}, out_valid}, '0);
    check("R1 word", out_word, '0);
    check("R1 rev", {{(W-1){1'b0}}, rev_flag}, '0);
    rst_n = 1'b1;
    send("R3 mode0 pass negative", 3'd0, -24'sd1234, 24'd100);
    send("R3 mode3 pass positive", 3'd3, 24'd777, 24'd100);
    send("R7 mode4 below floor", 3'd4, 24'd5, 24'd100);
    send("R7 mode7 negative small", 3'd7, -24'sd3, 24'd100);
    send("R3 mode1 positive", 3'd1, 24'd5000, 24'd100);
    send("R4 mode2 negative abs", 3'd2, -24'sd5000, 24'd100);
    send("R4 most negative", 3'd5, 24'h800000, 24'd100);
    send("R5 equal passes", 3'd6, -24'sd100, 24'd100);
    send("R5 below blocked", 3'd1, 24'd99, 24'd100);
    send("R6 default below", 3'd2, 24'd39, 24'd0);
    send("R6 default equal", 3'd2, -24'sd40, 24'd0);
    repeat (2) @(negedge clk);
    check("R2 drained", exp_q.size(), '0);
    send("R9 positive word", 3'd1, 24'd500, 24'd10);
    pulse_and_check("R9 pulse after positive", 1'b0);
    send("R9 blocked negative", 3'd1, -24'sd5, 24'd10);
    pulse_and_check("R9 pulse after blocked", 1'b0);
    send("R9 four-quadrant negative", 3'd0, -24'sd500, 24'd10);
    pulse_and_check("R9 pulse after 4Q", 1'b0);
    send("R9 negative no pulse", 3'd6, -24'sd500, 24'd10);
    repeat (3) @(negedge clk);
    check("R9 no pulse no rev", {{(W-1){1'b0}}, rev_flag}, '0);
    send("R9 then positive", 3'd6, 24'd500, 24'd10);
    pulse_and_check("R9 negative overwritten", 1'b0);
    send("R8 negative word", 3'd5, -24'sd500, 24'd10);
    pulse_and_check("R8 rev sets", 1'b1);
    send("R10 positive after", 3'd1, 24'd500, 24'd10);
    pulse_and_check("R10 stays after positive", 1'b1);
    send("R10 4Q after", 3'd3, 24'd1, 24'd10);
    repeat (3) @(negedge clk);
    check("R10 stays idle", {{(W-1){1'b0}}, rev_flag}, {{(W-1){1'b0}}, 1'b1});
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears rev", {{(W-1){1'b0}}, rev_flag}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule